// File: doc/BRIEF.md
# Load/Store Address Generator

This block sits between instruction decode and the data memory port of a 32-bit RISC core whose register file holds 64 entries. For each load or store it takes the decoded access size, the addressing form, the base register value, a second register value used as an index or post-modify step, and an 11-bit immediate magnitude with a separate sign. From these it forms the memory address, the byte lanes of a 64-bit data bus and the writeback value for the base register.

An immediate offset counts in units of the access size. A register offset counts in plain bytes. In the post-modify forms the access goes to the unmodified base, and the sum is written back to the base register. Every access has to be aligned to its own size. A double access must name an even data register. When either rule is broken, the block raises a fault and drops both the memory request and the base writeback.

The arithmetic is combinational. A parameter adds one register stage at the outputs. With the default setting every result appears one clock after the inputs that caused it.

Top module: `lsag_top`

## Requirements
- R1: The addressing form code `addrMode` selects: 0 base only, 1 base plus register index, 2 base plus signed immediate, 3 post-modify by register, 4 post-modify by signed immediate. Codes 5 to 7 act as base only. In the base-only form `memAddr` equals `baseVal`.
- R2: The size code `accSize` selects 0 byte (1 byte), 1 short (2 bytes), 2 word (4 bytes) or 3 double (8 bytes). Word is code 2. `memSize` repeats the code of the access.
- R3: An immediate offset equals `immMag` shifted left by `accSize`. When `immNeg` is 1 the offset is negated.
- R4: A register offset, used either as an index or as a post-modify step, is added as the raw byte value of `offReg` with no scaling.
- R5: In forms 3 and 4, `memAddr` equals `baseVal`, `wbEn` is 1 and `wbVal` equals the base plus the offset. Forms 0, 1 and 2 never assert `wbEn`.
- R6: All address sums wrap modulo 2^32.
- R7: When the address is not a multiple of the access size in bytes, `alignFault` is 1.
- R8: A double access with an odd `dataReg` sets `regFault`. Odd registers raise no fault at the other sizes.
- R9: In any cycle with a fault, `memReq`, `wbEn` and `byteEn` are all 0.
- R10: While `memReq` is 1, bit i of `byteEn` is set exactly when memAddr[2:0] <= i < memAddr[2:0] + size in bytes.
- R11: With `accValid` at 0 there is no request, no writeback and no fault. With the default output stage, results appear one clock after their inputs, and reset clears every output to 0.
- R12: A post-modify immediate with magnitude 1, the negative sign and word size gives a writeback of the base minus exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| accValid | input | 1 | A decoded load/store is present |
| accSize | input | 2 | Access size code |
| addrMode | input | 3 | Addressing form code |
| baseVal | input | 32 | Base register value |
| offReg | input | 32 | Index or post-modify register value |
| immMag | input | 11 | Immediate magnitude |
| immNeg | input | 1 | Immediate sign, 1 for negative |
| dataReg | input | 6 | Number of the data register |
| memReq | output | 1 | Memory request strobe |
| memAddr | output | 32 | Effective memory address |
| byteEn | output | 8 | Byte lanes of the 64-bit bus |
| memSize | output | 2 | Size code of the access |
| wbEn | output | 1 | Base register writeback enable |
| wbVal | output | 32 | New base register value |
| alignFault | output | 1 | Misaligned address |
| regFault | output | 1 | Odd data register on a double access |

## Verification
With the default output stage, every output (address, lanes, writeback and both faults) is due one clock edge after its inputs are applied. The bench changes the inputs on a falling edge, waits for the next rising edge, and samples 1 ns after it. That point falls after the output register has updated and before the inputs change again. The check right after reset is taken before any access has been applied, so it sees only the cleared register.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

  typedef enum logic [2:0] {
    MODE_BASE     = 3'd0,
    MODE_IDX_REG  = 3'd1,
    MODE_IDX_IMM  = 3'd2,
    MODE_POST_REG = 3'd3,
    MODE_POST_IMM = 3'd4
  } lsag_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE   = 2'd0,
    SZ_SHORT  = 2'd1,
    SZ_WORD   = 2'd2,
    SZ_DOUBLE = 2'd3
  } lsag_size_e;

  // strobes from control to datapath
  typedef struct packed {
    logic useOffset;  // add an offset at all
    logic useImm;     // offset is the scaled immediate
    logic postMod;    // access uses the unmodified base
  } lsag_strobe_t;

endpackage

// File: rtl/lsag_dpath.sv
module lsag_dpath
  import lsag_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IMM_W     = 11,
  parameter int BUS_BYTES = 8,
  localparam int LANE_W   = $clog2(BUS_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lsag_strobe_t      strobe,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] offReg,
  input  logic [IMM_W-1:0]  immMag,
  input  logic              immNeg,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] nextBase,
  output logic [LANE_W-1:0] addrLow,
  output logic [BUS_BYTES-1:0] laneMask
);

  localparam int CNT_W = LANE_W + 2;

  logic [ADDR_W-1:0] immExt;
  logic [ADDR_W-1:0] immScaled;
  logic [ADDR_W-1:0] immSigned;
  logic [ADDR_W-1:0] offSel;
  logic [ADDR_W-1:0] sumAddr;
  logic [CNT_W-1:0]  laneLo;
  logic [CNT_W-1:0]  laneHi;
  logic [CNT_W-1:0]  sizeBytes;

  always_comb begin
    immExt    = ADDR_W'(immMag);
    immScaled = immExt << accSize;
    immSigned = immNeg ? (~immScaled + 1'b1) : immScaled;
    if (!strobe.useOffset)  offSel = '0;
    else if (strobe.useImm) offSel = immSigned;
    else                    offSel = offReg;
    sumAddr  = baseVal + offSel;
    effAddr  = strobe.postMod ? baseVal : sumAddr;
    nextBase = sumAddr;
    addrLow  = effAddr[LANE_W-1:0];
  end

  assign sizeBytes = CNT_W'(1) << accSize;
  assign laneLo    = CNT_W'(addrLow);
  assign laneHi    = laneLo + sizeBytes;

  for (genvar lane = 0; lane < BUS_BYTES; lane++) begin : g_lane
    assign laneMask[lane] = (CNT_W'(lane) >= laneLo) && (CNT_W'(lane) < laneHi);
  end

  AST_POST_USES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.postMod |-> (effAddr == baseVal)) else $error("post-modify address moved"); // R5

  AST_REG_OFFSET_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.useOffset && !strobe.useImm) |-> (nextBase - baseVal == offReg)) else $error("register offset scaled"); // R4

endmodule

// File: rtl/lsag_ctrl.sv
module lsag_ctrl
  import lsag_pkg::*;
#(
  parameter int REG_IDX_W = 6,
  parameter int LANE_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accValid,
  input  logic [1:0]           accSize,
  input  logic [2:0]           addrMode,
  input  logic [REG_IDX_W-1:0] dataReg,
  input  logic [LANE_W-1:0]    addrLow,
  output lsag_strobe_t         strobe,
  output logic                 memReq,
  output logic                 wbEn,
  output logic                 alignFault,
  output logic                 regFault
);

  logic [LANE_W-1:0] alignMask;
  logic              anyFault;

  always_comb begin
    strobe = '0;
    case (addrMode)
      MODE_IDX_REG:  strobe = '{useOffset: 1'b1, useImm: 1'b0, postMod: 1'b0};
      MODE_IDX_IMM:  strobe = '{useOffset: 1'b1, useImm: 1'b1, postMod: 1'b0};
      MODE_POST_REG: strobe = '{useOffset: 1'b1, useImm: 1'b0, postMod: 1'b1};
      MODE_POST_IMM: strobe = '{useOffset: 1'b1, useImm: 1'b1, postMod: 1'b1};
      default:       strobe = '0;
    endcase
  end

  assign alignMask  = LANE_W'((1 << accSize) - 1);
  assign alignFault = accValid && (|(addrLow & alignMask));
  assign regFault   = accValid && (accSize == SZ_DOUBLE) && dataReg[0];
  assign anyFault   = alignFault || regFault;
  assign memReq     = accValid && !anyFault;
  assign wbEn       = memReq && strobe.postMod;

  AST_DOUBLE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && accSize == SZ_DOUBLE && dataReg[0]) |-> regFault) else $error("odd pair missed"); // R8

  AST_FAULT_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (alignFault || regFault) |-> (!memReq && !wbEn)) else $error("request under fault"); // R9

  AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> ((addrLow & alignMask) == '0)) else $error("misaligned request"); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !accValid |-> (!memReq && !wbEn && !alignFault && !regFault)) else $error("idle activity"); // R11

endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IMM_W     = 11,
  parameter int REG_IDX_W = 6,
  parameter int BUS_BYTES = 8,
  parameter bit OUT_REG   = 1'b1,
  localparam int LANE_W   = $clog2(BUS_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accValid,
  input  logic [1:0]           accSize,
  input  logic [2:0]           addrMode,
  input  logic [ADDR_W-1:0]    baseVal,
  input  logic [ADDR_W-1:0]    offReg,
  input  logic [IMM_W-1:0]     immMag,
  input  logic                 immNeg,
  input  logic [REG_IDX_W-1:0] dataReg,
  output logic                 memReq,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [BUS_BYTES-1:0] byteEn,
  output logic [1:0]           memSize,
  output logic                 wbEn,
  output logic [ADDR_W-1:0]    wbVal,
  output logic                 alignFault,
  output logic                 regFault
);

  lsag_strobe_t       strobe;
  logic [ADDR_W-1:0]  effAddr;
  logic [ADDR_W-1:0]  nextBase;
  logic [LANE_W-1:0]  addrLow;
  logic [BUS_BYTES-1:0] laneMask;
  logic               memReqC;
  logic               wbEnC;
  logic               alignFaultC;
  logic               regFaultC;
  logic [BUS_BYTES-1:0] byteEnC;

  lsag_ctrl #(.REG_IDX_W(REG_IDX_W), .LANE_W(LANE_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accValid  (accValid),
    .accSize   (accSize),
    .addrMode  (addrMode),
    .dataReg   (dataReg),
    .addrLow   (addrLow),
    .strobe    (strobe),
    .memReq    (memReqC),
    .wbEn      (wbEnC),
    .alignFault(alignFaultC),
    .regFault  (regFaultC)
  );

  lsag_dpath #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .BUS_BYTES(BUS_BYTES)) i_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .accSize (accSize),
    .baseVal (baseVal),
    .offReg  (offReg),
    .immMag  (immMag),
    .immNeg  (immNeg),
    .effAddr (effAddr),
    .nextBase(nextBase),
    .addrLow (addrLow),
    .laneMask(laneMask)
  );

  assign byteEnC = memReqC ? laneMask : '0;

  if (OUT_REG) begin : g_outreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        memReq     <= 1'b0;
        memAddr    <= '0;
        byteEn     <= '0;
        memSize    <= '0;
        wbEn       <= 1'b0;
        wbVal      <= '0;
        alignFault <= 1'b0;
        regFault   <= 1'b0;
      end else begin
        memReq     <= memReqC;
        memAddr    <= effAddr;
        byteEn     <= byteEnC;
        memSize    <= accSize;
        wbEn       <= wbEnC;
        wbVal      <= nextBase;
        alignFault <= alignFaultC;
        regFault   <= regFaultC;
      end
    end
  end else begin : g_comb
    always_comb begin
      memReq     = memReqC;
      memAddr    = effAddr;
      byteEn     = byteEnC;
      memSize    = accSize;
      wbEn       = wbEnC;
      wbVal      = nextBase;
      alignFault = alignFaultC;
      regFault   = regFaultC;
    end
  end

  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    memReqC |-> ($countones(byteEnC) == (1 << accSize))) else $error("lane count wrong"); // R10

  AST_NO_LANES_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (alignFaultC || regFaultC) |-> (byteEnC == '0)) else $error("lanes under fault"); // R9

endmodule

// File: tb/test_lsag_top.sv
`timescale 1ns/1ps
module test_lsag_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accValid = 1'b0;
  logic [1:0]  accSize = 2'd2;
  logic [2:0]  addrMode = 3'd0;
  logic [31:0] baseVal = '0;
  logic [31:0] offReg = '0;
  logic [10:0] immMag = '0;
  logic        immNeg = 1'b0;
  logic [5:0]  dataReg = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic [7:0]  byteEn;
  logic [1:0]  memSize;
  logic        wbEn;
  logic [31:0] wbVal;
  logic        alignFault;
  logic        regFault;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lsag_top i_lsag_top (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accSize(accSize),
    .addrMode(addrMode), .baseVal(baseVal), .offReg(offReg), .immMag(immMag),
    .immNeg(immNeg), .dataReg(dataReg), .memReq(memReq), .memAddr(memAddr),
    .byteEn(byteEn), .memSize(memSize), .wbEn(wbEn), .wbVal(wbVal),
    .alignFault(alignFault), .regFault(regFault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // apply one access, wait one edge, compare all outputs against the rules
  task automatic runCase(input string tag, input logic valid, input logic [1:0] sz,
                         input logic [2:0] md, input logic [31:0] base,
                         input logic [31:0] off, input logic [10:0] mag,
                         input logic neg, input logic [5:0] rg);
    logic [31:0] bytes, scaled, offv, sum, addr;
    logic        post, aF, rF, ok;
    logic [7:0]  lanes;
    @(negedge clk);
    accValid = valid; accSize = sz; addrMode = md; baseVal = base;
    offReg = off; immMag = mag; immNeg = neg; dataReg = rg;
    bytes  = 32'd1 << sz;
    scaled = {21'd0, mag} * bytes;
    if (md == 3'd2 || md == 3'd4)      offv = neg ? (32'd0 - scaled) : scaled;
    else if (md == 3'd1 || md == 3'd3) offv = off;
    else                               offv = 32'd0;
    sum  = base + offv;
    post = (md == 3'd3 || md == 3'd4);
    addr = post ? base : sum;
    aF   = valid && ((addr % bytes) != 0);
    rF   = valid && (sz == 2'd3) && rg[0];
    ok   = valid && !aF && !rF;
    for (int i = 0; i < 8; i++)
      lanes[i] = ok && (i >= int'(addr[2:0])) && (i < int'(addr[2:0]) + int'(bytes));
    @(posedge clk);
    #1;
    chk({tag, " addr"},    64'(memAddr), 64'(addr));
    chk({tag, " req"},     64'(memReq), 64'(ok));
    chk({tag, " size"},    64'(memSize), 64'(sz));
    chk({tag, " lanes"},   64'(byteEn), 64'(lanes));
    chk({tag, " wbEn"},    64'(wbEn), 64'(ok && post));
    if (post) chk({tag, " wbVal"}, 64'(wbVal), 64'(sum));
    chk({tag, " alignF"},  64'(alignFault), 64'(aF));
    chk({tag, " regF"},    64'(regFault), 64'(rF));
  endtask

  task automatic testReset;
    #1;
    chk("R11 reset req",   64'(memReq), 64'd0);
    chk("R11 reset addr",  64'(memAddr), 64'd0);
    chk("R11 reset lanes", 64'(byteEn), 64'd0);
    chk("R11 reset wb",    64'(wbEn), 64'd0);
    chk("R11 reset flt",   64'({alignFault, regFault}), 64'd0);
  endtask

  task automatic testForms;
    runCase("R1 base word",      1, 2'd2, 3'd0, 32'h0000_1000, 32'h55, 11'd7, 0, 6'd1);
    runCase("R1 mode7 base",     1, 2'd0, 3'd7, 32'h0000_2003, 32'h10, 11'd3, 0, 6'd0);
    runCase("R4 index reg byte", 1, 2'd0, 3'd1, 32'h0000_3000, 32'h0000_0013, 11'd0, 0, 6'd2);
    runCase("R4 index reg word", 1, 2'd2, 3'd1, 32'h0000_3000, 32'h0000_0010, 11'd0, 0, 6'd2);
    runCase("R3 disp short pos", 1, 2'd1, 3'd2, 32'h0000_4000, 32'h0, 11'd5, 0, 6'd4);
    runCase("R3 disp double neg",1, 2'd3, 3'd2, 32'h0000_4000, 32'h0, 11'd3, 1, 6'd6);
    runCase("R3 disp max mag",   1, 2'd2, 3'd2, 32'h0001_0000, 32'h0, 11'h7FF, 0, 6'd8);
  endtask

  task automatic testPost;
    runCase("R5 post reg word",  1, 2'd2, 3'd3, 32'h0000_5000, 32'h0000_0001, 11'd0, 0, 6'd3);
    runCase("R5 post imm short", 1, 2'd1, 3'd4, 32'h0000_5002, 32'h0, 11'd9, 0, 6'd3);
    runCase("R12 post imm -1 w", 1, 2'd2, 3'd4, 32'h0000_6000, 32'h0, 11'd1, 1, 6'd0);
    chk("R12 base minus 4", 64'(wbVal), 64'h0000_5FFC);
  endtask

  task automatic testWrap;
    runCase("R6 wrap up",   1, 2'd2, 3'd2, 32'hFFFF_FFF8, 32'h0, 11'd4, 0, 6'd0);
    runCase("R6 wrap down", 1, 2'd3, 3'd4, 32'h0000_0008, 32'h0, 11'd2, 1, 6'd10);
    runCase("R6 wrap reg",  1, 2'd0, 3'd1, 32'hFFFF_FFFF, 32'h0000_0002, 11'd0, 0, 6'd0);
  endtask

  task automatic testFaults;
    runCase("R7 short odd",    1, 2'd1, 3'd0, 32'h0000_7001, 32'h0, 11'd0, 0, 6'd0);
    runCase("R7 word idx mis", 1, 2'd2, 3'd1, 32'h0000_7000, 32'h0000_0002, 11'd0, 0, 6'd0);
    runCase("R9 post reg mis", 1, 2'd2, 3'd3, 32'h0000_7004, 32'h0000_0001, 11'd0, 0, 6'd0);
    runCase("R9 post mis wb",  1, 2'd3, 3'd4, 32'h0000_7004, 32'h0, 11'd1, 0, 6'd0);
    runCase("R8 double odd",   1, 2'd3, 3'd0, 32'h0000_8000, 32'h0, 11'd0, 0, 6'd5);
    runCase("R8 dbl odd post", 1, 2'd3, 3'd4, 32'h0000_8000, 32'h0, 11'd1, 0, 6'd63);
    runCase("R8 word odd ok",  1, 2'd2, 3'd0, 32'h0000_8000, 32'h0, 11'd0, 0, 6'd5);
    runCase("R8 double even",  1, 2'd3, 3'd0, 32'h0000_8008, 32'h0, 11'd0, 0, 6'd62);
  endtask

  task automatic testLanes;
    for (int sz = 0; sz < 4; sz++) begin
      for (int lo = 0; lo < 8; lo += (1 << sz)) begin
        runCase("R10 lanes", 1, 2'(sz), 3'd0, 32'h0000_9000 + 32'(lo), 32'h0, 11'd0, 0, 6'd0);
      end
    end
    runCase("R2 size byte",   1, 2'd0, 3'd0, 32'h0000_9007, 32'h0, 11'd0, 0, 6'd0);
    runCase("R2 size double", 1, 2'd3, 3'd0, 32'h0000_9008, 32'h0, 11'd0, 0, 6'd0);
  endtask

  task automatic testIdle;
    runCase("R11 idle misalign", 0, 2'd2, 3'd4, 32'h0000_A001, 32'h0, 11'd1, 0, 6'd1);
    runCase("R11 idle dbl odd",  0, 2'd3, 3'd3, 32'h0000_A000, 32'h4, 11'd0, 0, 6'd7);
  endtask

  initial begin
    testReset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    testForms();
    testPost();
    testWrap();
    testFaults();
    testLanes();
    testIdle();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule